// File: doc/BRIEF.md
# Replay Divergence Trace Comparator

This block helps diagnose a faulty core by replaying a thread. In record mode it watches the instructions a core retires and stores only branches, loads and stores in a trace buffer. A load record keeps the value the load returned. Because those values are every input the thread reads, a later replay does not need any memory ordering. Each record keeps the event kind, the address (the effective address, or the branch PC) and a value. The value is the load or store data, or the taken bit for a branch.

In replay mode the same thread runs on another core. The block feeds that core the recorded value of the next expected load, so the thread runs deterministically and in isolation. It compares each replayed branch, load or store with the next stored record. At the first mismatch it latches the record index and a code for the differing field, then stops comparing. If every record matches, it reports that the replay is complete with no divergence.

Traces cover short windows. A window-start pulse empties the buffer and clears every result so that diagnosis can repeat window after window. If the buffer fills before the window ends, further records are dropped and an overflow flag rises.

Top module: `trace_diverge_cmp`

## Requirements
- R1: After reset, `ovf_o`, `div_o`, `done_o` and `ld_rdy_o` are 0, and `div_idx_o`, `div_field_o` and `ld_val_o` are 0.
- R2: Event kinds are 2'b01 branch, 2'b10 load, 2'b11 store and 2'b00 other. In record mode (`mode_i`=0), each valid branch, load or store is stored in retire order, starting at index 0 after a window start. Events of kind 2'b00 are neither stored nor compared, and they advance no pointer in either mode.
- R3: In replay mode (`mode_i`=1), when the next expected record is a load, `ld_rdy_o` is 1 and `ld_val_o` equals that load's recorded value. Otherwise both are 0.
- R4: In replay, each branch, load or store is compared with the next record on kind, address and value. For a branch the value is the taken bit alone, and `ev_data_i` is ignored.
- R5: On the first mismatch, `div_o` becomes 1 one clock later and `div_idx_o` holds the record index. `div_field_o` holds the field code: 1 for kind, 2 for address, 3 for value. If several fields differ, kind wins over address, and address wins over value.
- R6: Once `div_o` is 1, comparing stops and `div_o`, `div_idx_o` and `div_field_o` hold until the next window start.
- R7: When DEPTH records are held, further recorded events are dropped and `ovf_o` becomes 1. It stays 1 until the next window start.
- R8: In replay mode, `done_o` is 1 when all stored records have been matched and there is no divergence. Events that arrive after the end are ignored, so they neither raise `div_o` nor drop `done_o`.
- R9: `win_start_i` empties the buffer and clears every result one clock later. An event in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| win_start_i | input | 1 | Starts a new trace window |
| mode_i | input | 1 | 0 record, 1 replay |
| ev_valid_i | input | 1 | Retire event valid |
| ev_kind_i | input | 2 | Event kind code |
| ev_addr_i | input | AW | Effective address or branch PC |
| ev_data_i | input | DW | Load or store data |
| ev_taken_i | input | 1 | Branch outcome |
| ld_rdy_o | output | 1 | Next expected record is a load |
| ld_val_o | output | DW | Recorded value for that load |
| ovf_o | output | 1 | Buffer filled during recording |
| div_o | output | 1 | Divergence found |
| div_idx_o | output | IW | Index of first mismatching record |
| div_field_o | output | 2 | Field that differed |
| done_o | output | 1 | Replay matched the whole trace |

## Verification
The bench goes after the following corner cases, each of which a faulty design would get wrong in a visible way:
- **Field priority.** When kind and address both differ, a design with the wrong priority would report address instead of kind.
- **Branch data.** A design that compared branch data would report false divergences when only `ev_data_i` changes.
- **Sticky divergence.** A design that kept comparing after a mismatch would move `div_idx_o` on to a later record.
- **Overflow.** A design that wrote past the last entry would overwrite a record or lose the overflow flag.
- **Events past the end.** A design that did not ignore them would report a divergence or drop `done_o`.
- **Window start with an event.** A design that stored the event in the window-start cycle would leave a stale record, so the replay would never complete.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  typedef enum logic [1:0] {
    KIND_OTHER = 2'b00,
    KIND_BR    = 2'b01,
    KIND_LD    = 2'b10,
    KIND_ST    = 2'b11
  } ev_kind_e;

  typedef enum logic [1:0] {
    FLD_NONE  = 2'd0,
    FLD_KIND  = 2'd1,
    FLD_ADDR  = 2'd2,
    FLD_VALUE = 2'd3
  } fld_e;
endpackage

// File: rtl/tdc_store.sv
module tdc_store #(
  parameter int DEPTH = 16,
  parameter int AW    = 16,
  parameter int DW    = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [1:0]    wr_kind_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_val_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [1:0]    rd_kind_o,
  output logic [AW-1:0] rd_addr_o,
  output logic [DW-1:0] rd_val_o
);
  logic [1:0]    kind_m [DEPTH];
  logic [AW-1:0] addr_m [DEPTH];
  logic [DW-1:0] val_m  [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic ent_en;
    assign ent_en = wr_en_i && (wr_idx_i == IW'(g));
    always_ff @(posedge clk_i) begin
      if (ent_en) begin
        kind_m[g] <= wr_kind_i;
        addr_m[g] <= wr_addr_i;
        val_m[g]  <= wr_val_i;
      end
    end
  end

  assign rd_kind_o = kind_m[rd_idx_i];
  assign rd_addr_o = addr_m[rd_idx_i];
  assign rd_val_o  = val_m[rd_idx_i];
endmodule

// File: rtl/tdc_ptr.sv
module tdc_ptr #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          rec_ev_i,
  input  logic          adv_i,
  output logic [CW-1:0] wr_cnt_o,
  output logic [CW-1:0] rd_ptr_o,
  output logic          full_o,
  output logic          avail_o,
  output logic          ovf_o
);
  logic [CW-1:0] wr_cnt_q, wr_cnt_d;
  logic [CW-1:0] rd_ptr_q, rd_ptr_d;
  logic          ovf_q, ovf_d;

  assign full_o  = (wr_cnt_q == CW'(DEPTH));
  assign avail_o = (rd_ptr_q < wr_cnt_q);

  always_comb begin
    wr_cnt_d = wr_cnt_q;
    rd_ptr_d = rd_ptr_q;
    ovf_d    = ovf_q;
    if (clr_i) begin
      wr_cnt_d = '0;
      rd_ptr_d = '0;
      ovf_d    = 1'b0;
    end else begin
      if (rec_ev_i) begin
        if (full_o) ovf_d = 1'b1;
        else        wr_cnt_d = wr_cnt_q + CW'(1);
      end
      if (adv_i && avail_o) rd_ptr_d = rd_ptr_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_cnt_q <= '0;
      rd_ptr_q <= '0;
      ovf_q    <= 1'b0;
    end else begin
      wr_cnt_q <= wr_cnt_d;
      rd_ptr_q <= rd_ptr_d;
      ovf_q    <= ovf_d;
    end
  end

  assign wr_cnt_o = wr_cnt_q;
  assign rd_ptr_o = rd_ptr_q;
  assign ovf_o    = ovf_q;

  AST_WR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt_q <= CW'(DEPTH)); // R7
  AST_RD_LE_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ptr_q <= wr_cnt_q); // R8
  AST_OVF_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |-> full_o); // R7
  AST_OVF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q && !clr_i |=> ovf_q); // R7
  AST_CLR_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> wr_cnt_q == '0 && rd_ptr_q == '0 && !ovf_q); // R9
endmodule

// File: rtl/tdc_cmp.sv
module tdc_cmp
  import tdc_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic [1:0]    exp_kind_i,
  input  logic [AW-1:0] exp_addr_i,
  input  logic [DW-1:0] exp_val_i,
  input  logic [1:0]    got_kind_i,
  input  logic [AW-1:0] got_addr_i,
  input  logic [DW-1:0] got_val_i,
  output fld_e          fld_o
);
  logic kind_ne, addr_ne, val_ne;

  assign kind_ne = (exp_kind_i != got_kind_i);
  assign addr_ne = (exp_addr_i != got_addr_i);
  assign val_ne  = (exp_val_i  != got_val_i);

  always_comb begin
    if (kind_ne)      fld_o = FLD_KIND;
    else if (addr_ne) fld_o = FLD_ADDR;
    else if (val_ne)  fld_o = FLD_VALUE;
    else              fld_o = FLD_NONE;
  end
endmodule

// File: rtl/trace_diverge_cmp.sv
module trace_diverge_cmp
  import tdc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 16,
  parameter int DW    = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          win_start_i,
  input  logic          mode_i,
  input  logic          ev_valid_i,
  input  logic [1:0]    ev_kind_i,
  input  logic [AW-1:0] ev_addr_i,
  input  logic [DW-1:0] ev_data_i,
  input  logic          ev_taken_i,
  output logic          ld_rdy_o,
  output logic [DW-1:0] ld_val_o,
  output logic          ovf_o,
  output logic          div_o,
  output logic [IW-1:0] div_idx_o,
  output logic [1:0]    div_field_o,
  output logic          done_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          act, rec_ev, rep_ev, adv, div_set;
  logic [DW-1:0] ev_val;
  logic [CW-1:0] wr_cnt, rd_ptr;
  logic          full, avail;
  logic [1:0]    rd_kind;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_val;
  fld_e          mis;

  logic          div_q, div_d;
  logic [IW-1:0] idx_q, idx_d;
  fld_e          fld_q, fld_d;

  // branch records keep only the outcome bit as their value
  assign ev_val  = (ev_kind_i == KIND_BR) ? {{(DW-1){1'b0}}, ev_taken_i} : ev_data_i;
  assign act     = ev_valid_i && (ev_kind_i != KIND_OTHER) && !win_start_i;
  assign rec_ev  = act && !mode_i;
  assign rep_ev  = act && mode_i && !div_q && avail;
  assign div_set = rep_ev && (mis != FLD_NONE);
  assign adv     = rep_ev && (mis == FLD_NONE);

  tdc_ptr #(.DEPTH(DEPTH)) i_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (win_start_i),
    .rec_ev_i (rec_ev),
    .adv_i    (adv),
    .wr_cnt_o (wr_cnt),
    .rd_ptr_o (rd_ptr),
    .full_o   (full),
    .avail_o  (avail),
    .ovf_o    (ovf_o)
  );

  tdc_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_store (
    .clk_i     (clk_i),
    .wr_en_i   (rec_ev && !full),
    .wr_idx_i  (wr_cnt[IW-1:0]),
    .wr_kind_i (ev_kind_i),
    .wr_addr_i (ev_addr_i),
    .wr_val_i  (ev_val),
    .rd_idx_i  (rd_ptr[IW-1:0]),
    .rd_kind_o (rd_kind),
    .rd_addr_o (rd_addr),
    .rd_val_o  (rd_val)
  );

  tdc_cmp #(.AW(AW), .DW(DW)) i_cmp (
    .exp_kind_i (rd_kind),
    .exp_addr_i (rd_addr),
    .exp_val_i  (rd_val),
    .got_kind_i (ev_kind_i),
    .got_addr_i (ev_addr_i),
    .got_val_i  (ev_val),
    .fld_o      (mis)
  );

  always_comb begin
    div_d = div_q;
    idx_d = idx_q;
    fld_d = fld_q;
    if (win_start_i) begin
      div_d = 1'b0;
      idx_d = '0;
      fld_d = FLD_NONE;
    end else if (div_set) begin
      div_d = 1'b1;
      idx_d = rd_ptr[IW-1:0];
      fld_d = mis;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= 1'b0;
      idx_q <= '0;
      fld_q <= FLD_NONE;
    end else begin
      div_q <= div_d;
      idx_q <= idx_d;
      fld_q <= fld_d;
    end
  end

  assign ld_rdy_o    = mode_i && avail && (rd_kind == KIND_LD);
  assign ld_val_o    = ld_rdy_o ? rd_val : '0;
  assign div_o       = div_q;
  assign div_idx_o   = idx_q;
  assign div_field_o = fld_q;
  assign done_o      = mode_i && !div_q && !avail;

  AST_DIV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_q && !win_start_i |=> div_q && $stable(idx_q) && $stable(fld_q)); // R6
  AST_DIV_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_q |-> fld_q != FLD_NONE); // R5
  AST_DIV_IDX_RECORDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_q |-> CW'(idx_q) < wr_cnt); // R5
  AST_DIV_PTR_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_q && !win_start_i |=> $stable(rd_ptr)); // R6
  AST_REPLAY_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i && !win_start_i |=> $stable(wr_cnt)); // R2
endmodule

// File: tb/test_trace_diverge_cmp.sv
module test_trace_diverge_cmp;
  localparam int CLK_P = 10;
  localparam int DEPTH = 16;
  localparam int AW    = 16;
  localparam int DW    = 16;
  localparam int IW    = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic win_start, mode, ev_valid, ev_taken;
  logic [1:0] ev_kind;
  logic [AW-1:0] ev_addr;
  logic [DW-1:0] ev_data;
  logic ld_rdy, ovf, div, done;
  logic [DW-1:0] ld_val;
  logic [IW-1:0] div_idx;
  logic [1:0] div_field;

  int checks = 0;
  int errors = 0;

  // reference model state
  int m_kind[$];
  int m_addr[$];
  int m_val[$];
  int m_rd, m_ovf, m_div, m_idx, m_fld;

  trace_diverge_cmp #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_trace_diverge_cmp (
    .clk_i(clk), .rst_ni(rst_n), .win_start_i(win_start), .mode_i(mode),
    .ev_valid_i(ev_valid), .ev_kind_i(ev_kind), .ev_addr_i(ev_addr),
    .ev_data_i(ev_data), .ev_taken_i(ev_taken), .ld_rdy_o(ld_rdy),
    .ld_val_o(ld_val), .ovf_o(ovf), .div_o(div), .div_idx_o(div_idx),
    .div_field_o(div_field), .done_o(done)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void model_clear();
    m_kind.delete(); m_addr.delete(); m_val.delete();
    m_rd = 0; m_ovf = 0; m_div = 0; m_idx = 0; m_fld = 0;
  endfunction

  function automatic void model_step();
    int v, f;
    if (win_start) begin
      model_clear();
      return;
    end
    if (!ev_valid || ev_kind == 2'b00) return;
    v = (ev_kind == 2'b01) ? int'(ev_taken) : int'(ev_data);
    if (!mode) begin
      if (m_kind.size() < DEPTH) begin
        m_kind.push_back(int'(ev_kind));
        m_addr.push_back(int'(ev_addr));
        m_val.push_back(v);
      end else m_ovf = 1;
    end else if (m_div == 0 && m_rd < m_kind.size()) begin
      f = 0;
      if (m_kind[m_rd] != int'(ev_kind))      f = 1;
      else if (m_addr[m_rd] != int'(ev_addr)) f = 2;
      else if (m_val[m_rd] != v)              f = 3;
      if (f != 0) begin m_div = 1; m_idx = m_rd; m_fld = f; end
      else m_rd++;
    end
  endfunction

  task automatic compare_all();
    int e_rdy, e_val, e_done;
    e_rdy  = (mode && m_rd < m_kind.size() && m_kind[m_rd] == 2) ? 1 : 0;
    e_val  = e_rdy ? m_val[m_rd] : 0;
    e_done = (mode && m_div == 0 && m_rd == m_kind.size()) ? 1 : 0;
    chk("R3 ld_rdy model", int'(ld_rdy), e_rdy);
    chk("R3 ld_val model", int'(ld_val), e_val);
    chk("R7 ovf model", int'(ovf), m_ovf);
    chk("R5 div model", int'(div), m_div);
    chk("R5 div_idx model", int'(div_idx), m_idx);
    chk("R5 div_field model", int'(div_field), m_fld);
    chk("R8 done model", int'(done), e_done);
  endtask

  task automatic step(input logic ws, input logic md, input logic v, input int k,
                      input int a, input int d, input logic tk);
    win_start = ws; mode = md; ev_valid = v; ev_kind = 2'(k);
    ev_addr = AW'(a); ev_data = DW'(d); ev_taken = tk;
    @(posedge clk);
    model_step();
    #1;
    compare_all();
  endtask

  task automatic idle(input logic md);
    step(1'b0, md, 1'b0, 0, 0, 0, 1'b0);
  endtask

  // base trace: store, load, branch, other, load, branch, store
  int bk[7] = '{3, 2, 1, 0, 2, 1, 3};
  int ba[7] = '{16'h0100, 16'h0104, 16'h0200, 16'h0300, 16'h0108, 16'h0204, 16'h010C};
  int bd[7] = '{16'hAAAA, 16'h1234, 16'h5555, 16'h7777, 16'h0042, 16'h9999, 16'hBEEF};
  logic bt[7] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};

  task automatic record_base();
    step(1'b1, 1'b0, 1'b0, 0, 0, 0, 1'b0);
    for (int i = 0; i < 7; i++) step(1'b0, 1'b0, 1'b1, bk[i], ba[i], bd[i], bt[i]);
  endtask

  initial begin : watchdog
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_clear();
    rst_n = 1'b0; win_start = 0; mode = 0; ev_valid = 0; ev_kind = 0;
    ev_addr = 0; ev_data = 0; ev_taken = 0;
    #(CLK_P * 3);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 ovf", int'(ovf), 0);
    chk("R1 div", int'(div), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 ld_rdy", int'(ld_rdy), 0);
    chk("R1 div_idx", int'(div_idx), 0);
    chk("R1 div_field", int'(div_field), 0);
    chk("R1 ld_val", int'(ld_val), 0);

    // R2 R3 R4 R8: clean replay, branch data differs but is ignored
    record_base();
    idle(1'b1);
    chk("R3 first record is store", int'(ld_rdy), 0);
    for (int i = 0; i < 7; i++) begin
      if (i == 1) begin
        chk("R3 load ready", int'(ld_rdy), 1);
        chk("R3 load value", int'(ld_val), 16'h1234);
      end
      step(1'b0, 1'b1, 1'b1, bk[i], ba[i], (bk[i] == 1) ? bd[i] ^ 16'hFFFF : bd[i], bt[i]);
    end
    chk("R8 done after clean replay", int'(done), 1);
    chk("R4 branch data ignored", int'(div), 0);
    step(1'b0, 1'b1, 1'b1, 3, 16'h0F00, 16'h1111, 1'b0);
    chk("R8 event past end ignored div", int'(div), 0);
    chk("R8 event past end done", int'(done), 1);

    // R5 R6: address mismatch at record index 3 (second load)
    record_base();
    for (int i = 0; i < 7; i++)
      step(1'b0, 1'b1, 1'b1, bk[i], (i == 4) ? ba[i] + 4 : ba[i], bd[i], bt[i]);
    chk("R5 addr div", int'(div), 1);
    chk("R5 addr idx", int'(div_idx), 3);
    chk("R5 addr field", int'(div_field), 2);
    step(1'b0, 1'b1, 1'b1, 2, 16'hDEAD, 0, 1'b0);
    chk("R6 idx frozen", int'(div_idx), 3);
    chk("R6 field frozen", int'(div_field), 2);
    chk("R8 no done after div", int'(done), 0);

    // R5 priority: kind and address both differ at index 0
    record_base();
    step(1'b0, 1'b1, 1'b1, 2, 16'h0500, 16'hAAAA, 1'b0);
    chk("R5 kind priority field", int'(div_field), 1);
    chk("R5 kind priority idx", int'(div_idx), 0);

    // R4 R5: branch taken bit flipped at index 2
    record_base();
    for (int i = 0; i < 3; i++)
      step(1'b0, 1'b1, 1'b1, bk[i], ba[i], bd[i], (i == 2) ? ~bt[i] : bt[i]);
    chk("R4 taken mismatch field", int'(div_field), 3);
    chk("R4 taken mismatch idx", int'(div_idx), 2);

    // R5: store value mismatch at last record (index 5)
    record_base();
    for (int i = 0; i < 7; i++)
      step(1'b0, 1'b1, 1'b1, bk[i], ba[i], (i == 6) ? 16'hBEEE : bd[i], bt[i]);
    chk("R5 value field", int'(div_field), 3);
    chk("R5 value idx", int'(div_idx), 5);

    // R7: overflow, then R8 full-depth replay
    step(1'b1, 1'b0, 1'b0, 0, 0, 0, 1'b0);
    for (int i = 0; i < DEPTH + 2; i++) step(1'b0, 1'b0, 1'b1, 3, i * 4, i + 16'h40, 1'b0);
    chk("R7 overflow set", int'(ovf), 1);
    idle(1'b0);
    chk("R7 overflow held", int'(ovf), 1);
    for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b1, 1'b1, 3, i * 4, i + 16'h40, 1'b0);
    chk("R7 full trace replays done", int'(done), 1);
    chk("R7 no div on full trace", int'(div), 0);

    // R9: window start with a same-cycle event; nothing stored
    step(1'b1, 1'b0, 1'b1, 2, 16'h0400, 16'h0001, 1'b0);
    chk("R9 ovf cleared", int'(ovf), 0);
    idle(1'b1);
    chk("R9 event ignored, empty trace done", int'(done), 1);
    chk("R9 no load ready", int'(ld_rdy), 0);

    // R2: kind 00 events in replay do not advance
    record_base();
    step(1'b0, 1'b1, 1'b1, 0, 16'hFFFF, 16'hFFFF, 1'b0);
    chk("R2 other kind no div", int'(div), 0);
    step(1'b0, 1'b1, 1'b1, bk[0], ba[0], bd[0], bt[0]);
    chk("R2 pointer at load", int'(ld_rdy), 1);
    chk("R2 load value", int'(ld_val), 16'h1234);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule